// File: doc/BRIEF.md
# Variable-Size FFT Pass Scheduler

This block sequences the passes of a memory-based FFT engine whose transform length is picked at run time from 128, 256, 512, 1024 or 2048 points. A start pulse carries a size code. The block then hands out, one per valid/ready transfer, an ordered list of pass descriptors. Each descriptor tells a downstream datapath five things: which pass it is, the butterfly form to use, how many small transforms the pass holds, the step into a single shared twiddle table, and whether it is the final pass.

Every length is split as 16 × N4. The first pass is always a set of 16-point column transforms in 4×4 form. The row length N4 is then broken into one or two sub-passes, and that split depends on the size. All twiddles come from one table of 2048th roots of unity, so a stride of 2048/N selects the right subset. After the final transfer a one-cycle done pulse marks the end of the list. A size code outside the supported range produces a one-cycle error pulse and no descriptors.

Top module: `fft_pass_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `desc_valid_o`, `done_o` and `err_o` are low.
- R2: Size codes 0, 1, 2, 3 and 4 select 128, 256, 512, 1024 and 2048 points. A start with a legal code while idle raises `desc_valid_o` in the next cycle. The first descriptor is the column pass: kind 0, form 0 (4×4), count N/16.
- R3: After the column pass, the row passes follow, in the order given for each size. Kind 1 marks the first row pass and kind 2 the second. Form 1 is 4×2, form 2 is 4×1 and form 0 is 4×4. The schedules are: 128 → (1,4×2); 256 → (1,4×4); 512 → (1,4×2),(2,4×1); 1024 → (1,4×1),(2,4×4); 2048 → (1,4×2),(2,4×4).
- R4: `desc_count_o` equals N divided by the points of the descriptor's form: 16 for 4×4, 8 for 4×2 and 4 for 4×1.
- R5: `desc_stride_o` equals 2048/N (16, 8, 4, 2 or 1) on every descriptor.
- R6: While `desc_valid_o` is high and `desc_ready_i` is low, the descriptor and valid stay unchanged. The list advances only on a cycle where both are high. `desc_last_o` is high only on the final descriptor.
- R7: `done_o` is high for exactly one cycle, the cycle after the final transfer, and `desc_valid_o` is low in that cycle.
- R8: A start with code 5, 6 or 7 while idle raises `err_o` for exactly the next cycle and emits no descriptor.
- R9: A start while a list is being emitted is ignored. The list in progress continues unchanged.
- R10: A start in the cycle `done_o` is high is accepted. With `desc_ready_i` held high, the list goes out at one descriptor per cycle, far fewer than N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new schedule |
| size_code_i | input | 3 | Transform size code, sampled with start_i |
| desc_ready_i | input | 1 | Consumer accepts the current descriptor |
| desc_valid_o | output | 1 | Descriptor present |
| desc_kind_o | output | 2 | 0 column, 1 first row pass, 2 second row pass |
| desc_form_o | output | 2 | 0 is 4×4, 1 is 4×2, 2 is 4×1 |
| desc_count_o | output | 10 | Number of small transforms in the pass |
| desc_stride_o | output | 5 | Twiddle table step, 2048/N |
| desc_last_o | output | 1 | Final descriptor of the list |
| done_o | output | 1 | One-cycle pulse after the final transfer |
| err_o | output | 1 | One-cycle pulse for an unsupported size code |

## Verification
Two events can land in the same cycle: the done pulse that closes one list and the start that opens the next. The bench provokes this by raising start, with a fresh legal or illegal code, inside the done cycle of the previous list. It then judges the outcome by checking three things: the new list, or the error pulse, follows at once; the done pulse stays one cycle wide; and no descriptor is lost or repeated. Mid-list starts with random codes are also injected under random back-pressure to confirm that they leave the running list untouched.

// File: rtl/fft_sched_pkg.sv
`timescale 1ns/1ps
package fft_sched_pkg;

  typedef enum logic [1:0] {
    KIND_COL   = 2'd0,
    KIND_ROW_A = 2'd1,
    KIND_ROW_B = 2'd2
  } pass_kind_e;

  typedef enum logic [1:0] {
    FORM_4X4 = 2'd0,
    FORM_4X2 = 2'd1,
    FORM_4X1 = 2'd2
  } pass_form_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } sched_state_e;

  // log2 of points handled by one small transform of a given form
  function automatic logic [2:0] form_log2pts(pass_form_e f);
    case (f)
      FORM_4X2: form_log2pts = 3'd3;
      FORM_4X1: form_log2pts = 3'd2;
      default:  form_log2pts = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/fft_size_decode.sv
`timescale 1ns/1ps
module fft_size_decode #(
  parameter int CODE_W   = 3,
  parameter int LOG2_MIN = 7,
  parameter int LOG2_MAX = 11,
  parameter int LOG_W    = 4
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output logic [LOG_W-1:0]  log2n_o
);
  localparam int NUM_SIZES = LOG2_MAX - LOG2_MIN + 1;

  assign legal_o = (int'(code_i) < NUM_SIZES);
  assign log2n_o = LOG_W'(LOG2_MIN) + LOG_W'(code_i);
endmodule

// File: rtl/fft_pass_rom.sv
`timescale 1ns/1ps
module fft_pass_rom
  import fft_sched_pkg::*;
#(
  parameter int LOG2_MAX = 11,
  parameter int COL_LOG2 = 4,
  parameter int LOG_W    = 4,
  parameter int CNT_W    = 10,
  parameter int STRIDE_W = 5
) (
  input  logic [LOG_W-1:0]    log2n_i,
  input  logic [1:0]          idx_i,
  output pass_kind_e          kind_o,
  output pass_form_e          form_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic                last_o
);
  logic [LOG_W-1:0] row_log2;
  logic [1:0]       npass;
  pass_form_e       form_a, form_b;
  logic [LOG_W-1:0] cnt_shift;

  assign row_log2 = log2n_i - LOG_W'(COL_LOG2);

  // row-length refactoring per size
  always_comb begin
    npass  = 2'd3;
    form_a = FORM_4X2;
    form_b = FORM_4X4;
    case (row_log2)
      LOG_W'(3): begin npass = 2'd2; form_a = FORM_4X2; end
      LOG_W'(4): begin npass = 2'd2; form_a = FORM_4X4; end
      LOG_W'(5): begin form_a = FORM_4X2; form_b = FORM_4X1; end
      LOG_W'(6): begin form_a = FORM_4X1; form_b = FORM_4X4; end
      default:   begin form_a = FORM_4X2; form_b = FORM_4X4; end
    endcase
  end

  always_comb begin
    case (idx_i)
      2'd0:    begin kind_o = KIND_COL;   form_o = FORM_4X4; end
      2'd1:    begin kind_o = KIND_ROW_A; form_o = form_a;   end
      default: begin kind_o = KIND_ROW_B; form_o = form_b;   end
    endcase
  end

  assign cnt_shift = log2n_i - LOG_W'(form_log2pts(form_o));
  assign count_o   = CNT_W'(1) << cnt_shift;
  assign stride_o  = STRIDE_W'(1) << (LOG_W'(LOG2_MAX) - log2n_i);
  assign last_o    = (idx_i == npass - 2'd1);
endmodule

// File: rtl/fft_sched_fsm.sv
`timescale 1ns/1ps
module fft_sched_fsm
  import fft_sched_pkg::*;
#(
  parameter int LOG2_MIN = 7,
  parameter int LOG_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             legal_i,
  input  logic [LOG_W-1:0] log2n_d_i,
  input  logic             ready_i,
  input  logic             last_i,
  output logic [LOG_W-1:0] log2n_q_o,
  output logic [1:0]       idx_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             err_o
);
  sched_state_e     state_q;
  logic [1:0]       idx_q;
  logic [LOG_W-1:0] log2n_q;
  logic             done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
      log2n_q <= LOG_W'(LOG2_MIN);
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (legal_i) begin
              state_q <= ST_EMIT;
              idx_q   <= 2'd0;
              log2n_q <= log2n_d_i;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        default: begin
          // start_i is ignored here
          if (ready_i) begin
            if (last_i) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end
        end
      endcase
    end
  end

  assign valid_o   = (state_q == ST_EMIT);
  assign idx_o     = idx_q;
  assign log2n_q_o = log2n_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/fft_pass_sched.sv
`timescale 1ns/1ps
module fft_pass_sched
  import fft_sched_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int LOG2_MIN = 7,
  parameter int LOG2_MAX = 11,
  parameter int COL_LOG2 = 4,
  localparam int LOG_W    = $clog2(LOG2_MAX + 1),
  localparam int CNT_W    = LOG2_MAX - 1,
  localparam int STRIDE_W = LOG2_MAX - LOG2_MIN + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CODE_W-1:0]   size_code_i,
  input  logic                desc_ready_i,
  output logic                desc_valid_o,
  output logic [1:0]          desc_kind_o,
  output logic [1:0]          desc_form_o,
  output logic [CNT_W-1:0]    desc_count_o,
  output logic [STRIDE_W-1:0] desc_stride_o,
  output logic                desc_last_o,
  output logic                done_o,
  output logic                err_o
);
  logic             legal;
  logic [LOG_W-1:0] log2n_d, log2n_q;
  logic [1:0]       idx;
  pass_kind_e       kind;
  pass_form_e       form;
  logic             last;

  fft_size_decode #(
    .CODE_W(CODE_W), .LOG2_MIN(LOG2_MIN), .LOG2_MAX(LOG2_MAX), .LOG_W(LOG_W)
  ) u_dec (
    .code_i (size_code_i),
    .legal_o(legal),
    .log2n_o(log2n_d)
  );

  fft_sched_fsm #(
    .LOG2_MIN(LOG2_MIN), .LOG_W(LOG_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .legal_i  (legal),
    .log2n_d_i(log2n_d),
    .ready_i  (desc_ready_i),
    .last_i   (last),
    .log2n_q_o(log2n_q),
    .idx_o    (idx),
    .valid_o  (desc_valid_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  fft_pass_rom #(
    .LOG2_MAX(LOG2_MAX), .COL_LOG2(COL_LOG2), .LOG_W(LOG_W),
    .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)
  ) u_rom (
    .log2n_i (log2n_q),
    .idx_i   (idx),
    .kind_o  (kind),
    .form_o  (form),
    .count_o (desc_count_o),
    .stride_o(desc_stride_o),
    .last_o  (last)
  );

  assign desc_kind_o = kind;
  assign desc_form_o = form;
  assign desc_last_o = last;
endmodule

// File: rtl/fft_pass_sched_chk.sv
`timescale 1ns/1ps
module fft_pass_sched_chk #(
  parameter int CODE_W   = 3,
  parameter int CNT_W    = 10,
  parameter int STRIDE_W = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [CODE_W-1:0]   size_code_i,
  input logic                desc_ready_i,
  input logic                desc_valid_o,
  input logic [1:0]          desc_kind_o,
  input logic [1:0]          desc_form_o,
  input logic [CNT_W-1:0]    desc_count_o,
  input logic [STRIDE_W-1:0] desc_stride_o,
  input logic                desc_last_o,
  input logic                done_o,
  input logic                err_o
);
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_kind_o) &&
    $stable(desc_form_o) && $stable(desc_count_o) && $stable(desc_stride_o) &&
    $stable(desc_last_o)); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_ready_i && desc_last_o |=> done_o && !desc_valid_o); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !desc_valid_o && !done_o); // R8

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R8

  AST_STRIDE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> $onehot(desc_stride_o)); // R5

  AST_FIRST_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(desc_valid_o) |-> desc_kind_o == 2'd0 && desc_form_o == 2'd0); // R2

  AST_COUNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_count_o != '0); // R4
endmodule

bind fft_pass_sched fft_pass_sched_chk #(
  .CODE_W(CODE_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .size_code_i  (size_code_i),
  .desc_ready_i (desc_ready_i),
  .desc_valid_o (desc_valid_o),
  .desc_kind_o  (desc_kind_o),
  .desc_form_o  (desc_form_o),
  .desc_count_o (desc_count_o),
  .desc_stride_o(desc_stride_o),
  .desc_last_o  (desc_last_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/fft_pass_sched_tb.sv
`timescale 1ns/1ps
module fft_pass_sched_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] size_code_i = 3'd0;
  logic       desc_ready_i = 1'b0;
  logic       desc_valid_o;
  logic [1:0] desc_kind_o, desc_form_o;
  logic [9:0] desc_count_o;
  logic [4:0] desc_stride_o;
  logic       desc_last_o, done_o, err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  fft_pass_sched u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .size_code_i(size_code_i),
    .desc_ready_i(desc_ready_i), .desc_valid_o(desc_valid_o),
    .desc_kind_o(desc_kind_o), .desc_form_o(desc_form_o),
    .desc_count_o(desc_count_o), .desc_stride_o(desc_stride_o),
    .desc_last_o(desc_last_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_npass(input int code);
    return (code <= 1) ? 2 : 3;
  endfunction

  // packed {kind, form, count, stride, last}
  function automatic logic [31:0] exp_desc(input int code, input int idx);
    int n, kind, form, pts, cnt, stride, last;
    n = 128 << code;
    stride = 2048 / n;
    kind = idx;
    form = 0;
    if (idx == 1) begin
      case (code)
        0: form = 1; 1: form = 0; 2: form = 1; 3: form = 2; default: form = 1;
      endcase
    end else if (idx == 2) begin
      form = (code == 2) ? 2 : 0;
    end
    pts = (form == 0) ? 16 : (form == 1) ? 8 : 4;
    cnt = n / pts;
    last = (idx == exp_npass(code) - 1) ? 1 : 0;
    return {12'd0, 2'(kind), 2'(form), 10'(cnt), 5'(stride), 1'(last)};
  endfunction

  function automatic logic [31:0] act_desc();
    return {12'd0, desc_kind_o, desc_form_o, desc_count_o, desc_stride_o, desc_last_o};
  endfunction

  // Runs one start; returns at negedge+5 of the cycle after completion.
  task automatic run(input int code, input int rdy_pct, input bit chained, input bit inject);
    int idx = 0;
    int cycles = 0;
    bit injected = 0;
    if (!chained) @(negedge clk_i);
    start_i = 1'b1;
    size_code_i = 3'(code);
    if (code > 4) begin
      @(negedge clk_i);
      start_i = 1'b0;
      #5;
      check("R8 err pulse", {31'd0, err_o}, 32'd1);
      check("R8 no descriptor", {31'd0, desc_valid_o}, 32'd0);
      @(negedge clk_i);
      #5;
      check("R8 err one cycle", {30'd0, err_o, desc_valid_o}, 32'd0);
      return;
    end
    while (idx < exp_npass(code) && cycles < 200) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (inject && !injected && idx == 1) begin
        start_i = 1'b1;
        size_code_i = 3'($urandom_range(0, 7));
        injected = 1;
      end
      desc_ready_i = ($urandom_range(0, 99) < rdy_pct);
      cycles++;
      #5;
      if (!desc_valid_o) begin
        check("R2 valid during list", 32'd0, 32'd1);
        idx = 99;
      end else if (desc_ready_i) begin
        check(inject ? "R3 R4 R5 R9 descriptor" : "R3 R4 R5 R6 descriptor",
              act_desc(), exp_desc(code, idx));
        if (idx > 0 || desc_kind_o != 2'd0)
          check("R7 no early done", {31'd0, done_o}, 32'd0);
        idx++;
      end
    end
    @(negedge clk_i);
    start_i = 1'b0;
    desc_ready_i = 1'b0;
    #5;
    check("R7 done after last", {30'd0, done_o, desc_valid_o}, 32'd2);
    if (rdy_pct >= 100)
      check("R10 one per cycle", 32'(cycles), 32'(exp_npass(code)));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0F17));
    #35;
    check("R1 reset quiet", {29'd0, desc_valid_o, done_o, err_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #5;
    check("R1 after release", {29'd0, desc_valid_o, done_o, err_o}, 32'd0);

    // directed: every size, full throughput
    for (int c = 0; c < 5; c++) run(c, 100, 1'b0, 1'b0);
    // directed: hold then release (R6)
    @(negedge clk_i);
    start_i = 1'b1; size_code_i = 3'd4;
    @(negedge clk_i);
    start_i = 1'b0; desc_ready_i = 1'b0;
    #5;
    check("R2 first descriptor col", act_desc(), exp_desc(4, 0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); #5;
      check("R6 held under back-pressure", act_desc(), exp_desc(4, 0));
    end
    @(negedge clk_i); desc_ready_i = 1'b1;
    @(negedge clk_i); desc_ready_i = 1'b0; #5;
    check("R6 advance on transfer", act_desc(), exp_desc(4, 1));
    @(negedge clk_i); desc_ready_i = 1'b1;
    @(negedge clk_i); #5;
    check("R6 last descriptor", act_desc(), exp_desc(4, 2));
    @(negedge clk_i); desc_ready_i = 1'b0; #5;
    check("R7 done pulse", {30'd0, done_o, desc_valid_o}, 32'd2);
    // illegal codes
    for (int c = 5; c < 8; c++) run(c, 100, 1'b0, 1'b0);
    // back-to-back starts in done cycle
    run(2, 100, 1'b0, 1'b0);
    run(3, 100, 1'b1, 1'b0);
    run(7, 100, 1'b1, 1'b0);
    run(0, 100, 1'b0, 1'b0);
    run(4, 100, 1'b1, 1'b0);
    // random
    for (int t = 0; t < 60; t++) begin
      int code = $urandom_range(0, 7);
      run(code, $urandom_range(20, 100), ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule